// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps time of day and calendar position as a chain of packed BCD fields, from a millisecond digit up through hundredths and tenths of a second, seconds, minutes, hours, day of week, day of month and month. A fixed-rate tick enable, one pulse per millisecond, advances the lowest field. Each field carries into the next one only when it wraps on that same tick, and the whole chain runs synchronously on one clock.

A processor bus sees eight byte-wide registers. Each register holds one field, with the units digit in bits 3:0 and the tens digit in bits 7:4. Bits that a field does not need always read as zero, and a write leaves them clear. Every field also drives a rollover strobe, which other logic can use to build periodic interrupts.

The day-of-month limit comes from a simple month-length table. February always has 28 days, and there is no leap-year rule.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset, the fields at addresses 0 to 4 read 00h, and day of week, day of month and month read 01h. All rollover strobes are low.
- R2: Addresses 0 to 7 select, in order: milliseconds, hundredths/tenths, seconds, minutes, hours, day of week, day of month, month. Read data follows the address combinationally, with units in bits 3:0 and tens in bits 7:4.
- R3: The bits a field uses are given by these masks: ms F0h, hundredths FFh, seconds 7Fh, minutes 7Fh, hours 3Fh, day of week 07h, day of month 3Fh, month 1Fh. All other bits read 0 and are dropped on write.
- R4: Each clock with tick_i high raises the millisecond tens digit by one. From 90h it wraps to 00h and carries.
- R5: Hundredths wraps from 99h to 00h. Seconds and minutes each wrap from 59h to 00h. Each carries when it wraps.
- R6: Hours count 00h to 23h, then wrap to 00h and carry.
- R7: Day of week counts 01h to 07h, then wraps to 01h and carries.
- R8: Day of month wraps to 01h after the last day of the current month: 28 for February, 30 for months 4, 6, 9 and 11, and 31 for every other month. It carries when it wraps.
- R9: Month counts 01h to 12h, then wraps to 01h.
- R10: A write with wr_en_i high updates the addressed field at the next clock edge. It overrides any tick increment of that field in the same cycle, and that field does not carry in that cycle.
- R11: rollover_o[i] is high for exactly the one cycle after the edge at which field i wrapped on a tick. In that cycle the field shows its first value. A write never raises the strobe.
- R12: With tick_i and wr_en_i both low, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Millisecond count enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data, two BCD digits |
| rdata_o | output | 8 | Read data of the addressed field |
| rollover_o | output | 8 | Per-field wrap strobe, bit i for field i |

## Verification
A bus write and a tick-driven carry can hit the same field in the same cycle. The bench sets the lower fields to their limits, then raises a tick together with a write to a field that the carry would reach. A behavioural model predicts the result. The written value must win, no rollover strobe may appear for that field, and no field above it may move. Every field and strobe is compared with the model after each clock.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

   localparam int NUM_FIELDS = 8;
   localparam int BYTE_W     = 8;
   localparam int DOM_IDX    = 6;
   localparam int MON_IDX    = 7;

   typedef logic [BYTE_W-1:0] bcd_pair_t;

   // bits a field actually uses
   function automatic bcd_pair_t fld_mask(input int idx);
      case (idx)
         0:       return 8'hF0;
         1:       return 8'hFF;
         2, 3:    return 8'h7F;
         4:       return 8'h3F;
         5:       return 8'h07;
         6:       return 8'h3F;
         7:       return 8'h1F;
         default: return 8'h00;
      endcase
   endfunction

   // value a field returns to on wrap
   function automatic bcd_pair_t fld_first(input int idx);
      return (idx >= 5) ? 8'h01 : 8'h00;
   endfunction

   // fixed wrap point; the day-of-month entry is replaced by a table
   function automatic bcd_pair_t fld_last(input int idx);
      case (idx)
         0:       return 8'h90;
         1:       return 8'h99;
         2, 3:    return 8'h59;
         4:       return 8'h23;
         5:       return 8'h07;
         6:       return 8'h31;
         7:       return 8'h12;
         default: return 8'h00;
      endcase
   endfunction

   // units digit value at which the increment moves to the tens digit
   function automatic logic [3:0] fld_unit_top(input int idx);
      return (idx == 0) ? 4'd0 : 4'd9;
   endfunction

endpackage

// File: rtl/bcd_field_stage.sv
module bcd_field_stage
   import bcd_cal_pkg::*;
#(
   parameter bcd_pair_t   FIRST    = 8'h00,
   parameter bcd_pair_t   MASK     = 8'hFF,
   parameter logic [3:0]  UNIT_TOP = 4'd9
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      carry_i,
   input  logic      wr_i,
   input  bcd_pair_t wdata_i,
   input  bcd_pair_t last_i,
   output bcd_pair_t value_o,
   output logic      carry_o
);

   bcd_pair_t value_q;
   bcd_pair_t inc_val;
   logic      at_last;

   // BCD ordering matches binary ordering, so >= also catches stale values
   assign at_last = (value_q >= last_i);

   always_comb begin
      if (value_q[3:0] >= UNIT_TOP)
         inc_val = {value_q[7:4] + 4'd1, 4'd0};
      else
         inc_val = {value_q[7:4], value_q[3:0] + 4'd1};
   end

   assign carry_o = carry_i && at_last && !wr_i;

   always_ff @(posedge clk) begin
      if (!rst_n)
         value_q <= FIRST;
      else if (wr_i)
         value_q <= wdata_i & MASK;
      else if (carry_i)
         value_q <= at_last ? FIRST : (inc_val & MASK);
   end

   assign value_o = value_q;

endmodule

// File: rtl/month_last_day.sv
module month_last_day
   import bcd_cal_pkg::*;
(
   input  bcd_pair_t month_i,
   output bcd_pair_t last_o
);

   always_comb begin
      case (month_i)
         8'h02:                      last_o = 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
         default:                    last_o = 8'h31;
      endcase
   end

endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter
   import bcd_cal_pkg::*;
#(
   parameter int ADDR_W          = 3,
   parameter bit ROLL_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   output logic [7:0]        rollover_o
);

   localparam int NF = NUM_FIELDS;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must reach all eight fields");
   end

   logic [NF:0]              carry;
   logic [NF-1:0]            wrap;
   logic [NF-1:0]            wr_sel;
   logic [NF-1:0][BYTE_W-1:0] fld_vec;
   bcd_pair_t                dom_last;

   assign carry[0] = tick_i;

   month_last_day u_mlen (
      .month_i (fld_vec[MON_IDX]),
      .last_o  (dom_last)
   );

   for (genvar g = 0; g < NF; g++) begin : g_stage
      bcd_pair_t last_w;
      if (g == DOM_IDX) begin : g_var_last
         assign last_w = dom_last;
      end else begin : g_fix_last
         assign last_w = fld_last(g);
      end

      assign wr_sel[g] = wr_en_i && (int'(addr_i) == g);

      bcd_field_stage #(
         .FIRST    (fld_first(g)),
         .MASK     (fld_mask(g)),
         .UNIT_TOP (fld_unit_top(g))
      ) u_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .carry_i (carry[g]),
         .wr_i    (wr_sel[g]),
         .wdata_i (wdata_i),
         .last_i  (last_w),
         .value_o (fld_vec[g]),
         .carry_o (carry[g+1])
      );

      assign wrap[g] = carry[g+1];
   end

   if (ROLL_REGISTERED) begin : g_roll_reg
      logic [NF-1:0] roll_q;
      always_ff @(posedge clk) begin
         if (!rst_n) roll_q <= '0;
         else        roll_q <= wrap;
      end
      assign rollover_o = roll_q;
   end else begin : g_roll_comb
      assign rollover_o = wrap;
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NF; i++)
         if (int'(addr_i) == i) rdata_o = fld_vec[i];
   end

endmodule

// File: rtl/bcd_calendar_counter_chk.sv
module bcd_calendar_counter_chk
   import bcd_cal_pkg::*;
#(
   parameter int ADDR_W          = 3,
   parameter bit ROLL_REGISTERED = 1'b1
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          tick_i,
   input logic                          wr_en_i,
   input logic [ADDR_W-1:0]             addr_i,
   input logic [7:0]                    wdata_i,
   input logic [7:0]                    rdata_o,
   input logic [7:0]                    rollover_o,
   input logic [NUM_FIELDS-1:0][7:0]    fld_vec
);

   assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(addr_i) < NUM_FIELDS) |-> ((rdata_o & ~fld_mask(int'(addr_i))) == 8'h00));

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !wr_en_i) |=> $stable(fld_vec));

   assert_write_sec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && int'(addr_i) == 2) |=> (fld_vec[2] == ($past(wdata_i) & 8'h7F)));

   assert_hours_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fld_vec[4] <= 8'h23);

   assert_roll_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rollover_o[0] |=> !rollover_o[0]);

   if (ROLL_REGISTERED) begin : g_reg_chk
      assert_roll_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
         rollover_o[4] |-> (fld_vec[4] == 8'h00));
   end

endmodule

bind bcd_calendar_counter bcd_calendar_counter_chk #(
   .ADDR_W          (ADDR_W),
   .ROLL_REGISTERED (ROLL_REGISTERED)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_i     (tick_i),
   .wr_en_i    (wr_en_i),
   .addr_i     (addr_i),
   .wdata_i    (wdata_i),
   .rdata_o    (rdata_o),
   .rollover_o (rollover_o),
   .fld_vec    (fld_vec)
);

// File: tb/bcd_calendar_counter_tb.sv
`timescale 1ns/1ps
module bcd_calendar_counter_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [2:0] addr_i = '0;
   logic [7:0] wdata_i = '0;
   logic [7:0] rdata_o;
   logic [7:0] rollover_o;

   int checks = 0;
   int fails  = 0;
   int mv[8];
   logic [7:0] mroll = '0;

   always #4 clk = ~clk;

   bcd_calendar_counter dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rollover_o(rollover_o)
   );

   function automatic int mlen(input int m);
      if (m == 2) return 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   function automatic int lim(input int i, input int mon);
      case (i)
         0: return 9;  1: return 99; 2: return 59; 3: return 59;
         4: return 23; 5: return 7;  6: return mlen(mon);
         default: return 12;
      endcase
   endfunction

   function automatic int first_of(input int i);
      return (i >= 5) ? 1 : 0;
   endfunction

   function automatic logic [7:0] mask_of(input int i);
      case (i)
         0: return 8'hF0; 1: return 8'hFF; 2: return 8'h7F; 3: return 8'h7F;
         4: return 8'h3F; 5: return 8'h07; 6: return 8'h3F; default: return 8'h1F;
      endcase
   endfunction

   function automatic logic [7:0] enc(input int i, input int v);
      if (i == 0) return 8'(v << 4);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int dec(input int i, input logic [7:0] b);
      if (i == 0) return int'(b[7:4]);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic string fld_req(input int i);
      case (i)
         0: return "R4"; 1, 2, 3: return "R5"; 4: return "R6";
         5: return "R7"; 6: return "R8"; default: return "R9";
      endcase
   endfunction

   task automatic model_step(input logic t, input logic w, input int a, input logic [7:0] d);
      int nv[8];
      logic c;
      c = t;
      mroll = '0;
      for (int i = 0; i < 8; i++) begin
         nv[i] = mv[i];
         if (c) begin
            if (w && a == i) c = 1'b0;
            else if (mv[i] >= lim(i, mv[7])) begin
               nv[i] = first_of(i);
               mroll[i] = 1'b1;
            end else begin
               nv[i] = mv[i] + 1;
               c = 1'b0;
            end
         end
      end
      if (w) nv[a] = dec(a, d & mask_of(a));
      for (int i = 0; i < 8; i++) mv[i] = nv[i];
   endtask

   task automatic compare_all(input string tag);
      checks++;
      if (rollover_o !== mroll) begin
         fails++;
         $display("FAIL %s/R11 rollover got %h exp %h", tag, rollover_o, mroll);
      end
      for (int i = 0; i < 8; i++) begin
         addr_i = 3'(i);
         #0.25;
         checks++;
         if (rdata_o !== enc(i, mv[i])) begin
            fails++;
            $display("FAIL %s/%s field %0d got %h exp %h", tag, fld_req(i), i, rdata_o, enc(i, mv[i]));
         end
      end
   endtask

   task automatic cyc(input string tag, input logic t, input logic w, input int a, input logic [7:0] d);
      @(negedge clk);
      tick_i = t; wr_en_i = w; addr_i = 3'(a); wdata_i = d;
      model_step(t, w, a, d);
      @(posedge clk);
      #1;
      tick_i = 1'b0; wr_en_i = 1'b0;
      compare_all(tag);
   endtask

   task automatic wr(input string tag, input int a, input logic [7:0] d);
      cyc(tag, 1'b0, 1'b1, a, d);
   endtask

   task automatic set_edge(input int mon, input int dom, input int dow);
      wr("R2", 7, enc(7, mon));
      wr("R2", 6, enc(6, dom));
      wr("R2", 5, enc(5, dow));
      wr("R2", 4, 8'h23);
      wr("R2", 3, 8'h59);
      wr("R2", 2, 8'h59);
      wr("R2", 1, 8'h99);
      wr("R2", 0, 8'h90);
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) mv[i] = first_of(i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      compare_all("R1");

      // plain counting, R4 carry into hundredths
      for (int k = 0; k < 25; k++) cyc("R4", 1'b1, 1'b0, 0, 8'h00);

      // idle hold
      for (int k = 0; k < 4; k++) cyc("R12", 1'b0, 1'b0, 0, 8'h00);

      // unused bits dropped on write
      wr("R3", 4, 8'hE3);
      wr("R3", 5, 8'hF5);
      wr("R3", 0, 8'h5F);
      wr("R3", 2, 8'hC7);
      wr("R3", 7, 8'hE9);

      // full cascade through every month end
      for (int m = 1; m <= 12; m++) begin
         set_edge(m, mlen(m), 7);
         cyc("R8", 1'b1, 1'b0, 0, 8'h00);
         cyc("R11", 1'b0, 1'b0, 0, 8'h00);
      end

      // write collides with carry: write wins, carry stops there
      set_edge(5, 31, 3);
      cyc("R10", 1'b1, 1'b1, 1, 8'h42);
      cyc("R10", 1'b0, 1'b0, 0, 8'h00);
      set_edge(5, 31, 3);
      cyc("R10", 1'b1, 1'b1, 4, 8'h11);
      set_edge(5, 31, 3);
      cyc("R10", 1'b1, 1'b1, 0, 8'h30);

      // mixed run
      for (int k = 0; k < 400; k++)
         cyc("R4", (k % 3) != 1, 1'b0, 0, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule